// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers 32 interrupt sources and delivers each one to a grid of 16 output lines. The grid has four cores, and each core has four parent lines. A small memory-mapped port configures every source. A polarity bit picks which sense is active. A sense-mode bit picks level or edge detection. An enable bit gates the source. A route byte names the parent lines and the cores that the source drives. Enables change through two write-only registers. One sets the enable bits that are written as one. The other clears them. The current enable mask is read back at its own offset.

Every source passes through a two-stage synchronizer. In level mode the synchronized input, compared with its polarity bit, is the pending state. In edge mode the selected transition sets a pending latch. Software clears that latch by writing a one to the status bit. Disabling the source also clears it. Software reads a global status word holding every enabled, pending source, and one status word per core holding the enabled, pending sources routed to that core.

The read port is combinational. Read data follows the address in the same cycle. Register writes take effect at the next rising clock edge.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset all enables are 0, the sense-mode word at 0x34 is 0 (level), the polarity word at 0x30 is all ones (active-high), every route byte is 0, all output lines are low, and the enable readback at 0x24 is 0.
- R2: A write to 0x28 sets each enable bit whose data bit is 1 and leaves each enable bit whose data bit is 0 unchanged.
- R3: A write to 0x2C clears each enable bit whose data bit is 1. Writing all ones disables every source. No other write changes the enable mask.
- R4: The route byte of source n sits at byte offset n (0x00 to 0x1F). A write takes data bits [7:0]. A read returns the byte in bits [7:0] with the upper bits zero. Bits [7:4] select parent lines 0 to 3 and bits [3:0] select cores 0 to 3.
- R5: In level mode (sense bit 0) a source is pending while its synchronized input equals its polarity bit. An input change reaches the outputs after exactly two rising clock edges.
- R6: In edge mode (sense bit 1) an enabled source latches pending on a rising transition when its polarity bit is 1, and on a falling transition when its polarity bit is 0. The latch stays set after the input returns. The other transition does not set it.
- R7: An edge latch clears when a 1 is written to its bit of the status word at 0x40. Zero bits of that write leave latches alone. An edge latch also clears when the source is disabled, and it stays clear on re-enable until a new edge arrives.
- R8: A read of 0x40 returns the enabled, pending sources (bit n is source n). Reads of 0x24, 0x30 and 0x34 return the enable, polarity and sense-mode words.
- R9: Output line index c*4+p is high when at least one enabled, pending source has route bit c and route bit 4+p both set. Several such sources on one line are ORed together.
- R10: A read of 0x50+4*c returns the enabled, pending sources whose route byte has core bit c set.
- R11: Reads of any offset not listed above return zero, including the write-only offsets 0x28 and 0x2C.
- R12: A disabled source has no effect on any output line or status word, whatever its input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Interrupt source inputs, asynchronous to clk |
| bus_wr_i | input | 1 | Write strobe for the register port |
| bus_addr_i | input | 8 | Byte offset for reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, same cycle |
| irq_line_o | output | 16 | Core/parent lines, index core*4+parent |

## Verification
The assertions check the enable register on every cycle. A set write may only add bits, a clear write must remove the written bits, and any other cycle leaves the mask unchanged. They also check that no edge latch survives a cycle in which its source was disabled, and that a raised output line always comes with a nonzero active set and core status. Which line a given route byte lights, the two-edge level latency, the choice of transition under each polarity, write-one clearing of status, and zero reads of unmapped offsets can only be shown by the bench's scenarios.

// File: rtl/irq_route_pkg.sv
// Shared constants for the routed interrupt controller: register offsets,
// the route-byte layout and the bus widths. Offsets are byte addresses.
package irq_route_pkg;
    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 32;
    localparam int ROUTE_W      = 8;
    localparam int PAR_LSB      = 4;   // parent select starts at this route bit
    localparam int CORE_STRIDE  = 4;

    localparam logic [ADDR_W-1:0] OFS_EN_STATE = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_EN_SET   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_POL      = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_SENSE    = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_CORE0    = 8'h50;
endpackage

// File: rtl/irq_route_regs.sv
// Register file and read mux.
// Holds the enable, polarity and sense-mode words and one route byte per
// source. Enables change only through the set/clear registers. A write to the
// status offset produces a one-cycle clear pulse for the edge latches.
// Assumes NUM_SRC <= DATA_W and single-cycle, non-overlapping bus writes.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CORE = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_wr_i,
    input  logic [ADDR_W-1:0]                   bus_addr_i,
    input  logic [DATA_W-1:0]                   bus_wdata_i,
    output logic [DATA_W-1:0]                   bus_rdata_o,
    input  logic [NUM_SRC-1:0]                  active_i,
    input  logic [NUM_CORE-1:0][NUM_SRC-1:0]    core_stat_i,
    output logic [NUM_SRC-1:0]                  en_o,
    output logic [NUM_SRC-1:0]                  pol_o,
    output logic [NUM_SRC-1:0]                  sense_o,
    output logic [NUM_SRC-1:0][ROUTE_W-1:0]     route_o,
    output logic [NUM_SRC-1:0]                  stat_clr_o
);
    logic [NUM_SRC-1:0] wbits;
    logic wr_set, wr_clr, wr_pol, wr_sense;

    assign wbits    = bus_wdata_i[NUM_SRC-1:0];
    assign wr_set   = bus_wr_i && (bus_addr_i == OFS_EN_SET);
    assign wr_clr   = bus_wr_i && (bus_addr_i == OFS_EN_CLR);
    assign wr_pol   = bus_wr_i && (bus_addr_i == OFS_POL);
    assign wr_sense = bus_wr_i && (bus_addr_i == OFS_SENSE);

    // Write-one pulse that clears edge latches.
    assign stat_clr_o = (bus_wr_i && (bus_addr_i == OFS_STATUS)) ? wbits : '0;

    // Enable mask: set-by-one and clear-by-one access.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_o <= '0;
        else if (wr_set) en_o <= en_o | wbits;
        else if (wr_clr) en_o <= en_o & ~wbits;
    end

    // Polarity and sense-mode words, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_o   <= '1;
            sense_o <= '0;
        end else begin
            if (wr_pol)   pol_o   <= wbits;
            if (wr_sense) sense_o <= wbits;
        end
    end

    // One route byte per source, at byte offset equal to its index.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_route
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_o[s] <= '0;
            else if (bus_wr_i && (bus_addr_i == ADDR_W'(s)))
                route_o[s] <= bus_wdata_i[ROUTE_W-1:0];
        end
    end

    // Read mux; every unmapped offset returns zero.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            OFS_EN_STATE: bus_rdata_o[NUM_SRC-1:0] = en_o;
            OFS_POL:      bus_rdata_o[NUM_SRC-1:0] = pol_o;
            OFS_SENSE:    bus_rdata_o[NUM_SRC-1:0] = sense_o;
            OFS_STATUS:   bus_rdata_o[NUM_SRC-1:0] = active_i;
            default:      bus_rdata_o = '0;
        endcase
        for (int s = 0; s < NUM_SRC; s++)
            if (bus_addr_i == ADDR_W'(s))
                bus_rdata_o[ROUTE_W-1:0] = route_o[s];
        for (int c = 0; c < NUM_CORE; c++)
            if (bus_addr_i == OFS_CORE0 + ADDR_W'(CORE_STRIDE * c))
                bus_rdata_o[NUM_SRC-1:0] = core_stat_i[c];
    end
endmodule

// File: rtl/irq_route_cond.sv
// Per-source conditioning.
// Each input is synchronized through two flops. A third flop holds the
// previous synchronized value for edge detection. Level mode compares the
// synchronized input with the polarity bit. Edge mode sets a latch on the
// selected transition. The latch is cleared by disable, by leaving edge mode,
// or by a status write-one; a new edge in the same cycle as a status clear wins.
// Assumes src_i may be asynchronous to clk.
module irq_route_cond #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] pol_i,
    input  logic [NUM_SRC-1:0] sense_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic sync_a, sync_b, prev_q, latch_q, edge_hit;

        // Two-stage synchronizer plus history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_a <= 1'b0;
                sync_b <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                sync_a <= src_i[s];
                sync_b <= sync_a;
                prev_q <= sync_b;
            end
        end

        assign edge_hit = pol_i[s] ? (sync_b & ~prev_q) : (~sync_b & prev_q);

        // Edge pending latch.
        always_ff @(posedge clk) begin
            if (!rst_n || !en_i[s] || !sense_i[s]) latch_q <= 1'b0;
            else if (edge_hit)                    latch_q <= 1'b1;
            else if (clr_i[s])                    latch_q <= 1'b0;
        end

        assign pend_o[s] = sense_i[s] ? latch_q : (sync_b == pol_i[s]);
    end
endmodule

// File: rtl/irq_route_fabric.sv
// Routing fabric.
// Gates pending with enable. Each core/parent line is the OR of the active
// sources whose route byte selects both. Also forms the per-core status words.
// Assumes NUM_CORE <= PAR_LSB and NUM_PAR <= ROUTE_W - PAR_LSB.
module irq_route_fabric
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_PAR  = 4,
    parameter int NUM_CORE = 4
) (
    input  logic [NUM_SRC-1:0]                pend_i,
    input  logic [NUM_SRC-1:0]                en_i,
    input  logic [NUM_SRC-1:0][ROUTE_W-1:0]   route_i,
    output logic [NUM_SRC-1:0]                active_o,
    output logic [NUM_CORE-1:0][NUM_SRC-1:0]  core_stat_o,
    output logic [NUM_CORE*NUM_PAR-1:0]       line_o
);
    logic [NUM_CORE-1:0][NUM_SRC-1:0] core_hit;
    logic [NUM_PAR-1:0][NUM_SRC-1:0]  par_hit;

    assign active_o = pend_i & en_i;

    // Transpose route bytes into per-core and per-parent source masks.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_tr
        for (genvar c = 0; c < NUM_CORE; c++) begin : g_c
            assign core_hit[c][s] = route_i[s][c];
        end
        for (genvar p = 0; p < NUM_PAR; p++) begin : g_p
            assign par_hit[p][s] = route_i[s][PAR_LSB+p];
        end
    end

    // Grid of wide ORs, one per core/parent pair.
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        assign core_stat_o[c] = active_o & core_hit[c];
        for (genvar p = 0; p < NUM_PAR; p++) begin : g_par
            assign line_o[c*NUM_PAR+p] = |(active_o & core_hit[c] & par_hit[p]);
        end
    end
endmodule

// File: rtl/irq_route_ctrl.sv
// Routed interrupt controller, top level.
// Connects the register file, the per-source conditioning and the routing
// fabric. Line index is core*NUM_PAR + parent.
// Assumes a synchronous active-low reset and a combinational read port.
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_PAR  = 4,
    parameter int NUM_CORE = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SRC-1:0]           src_i,
    input  logic                         bus_wr_i,
    input  logic [ADDR_W-1:0]            bus_addr_i,
    input  logic [DATA_W-1:0]            bus_wdata_i,
    output logic [DATA_W-1:0]            bus_rdata_o,
    output logic [NUM_CORE*NUM_PAR-1:0]  irq_line_o
);
    logic [NUM_SRC-1:0]               en_q, pol_q, sense_q, stat_clr, pend, active;
    logic [NUM_SRC-1:0][ROUTE_W-1:0]  route_q;
    logic [NUM_CORE-1:0][NUM_SRC-1:0] core_stat;

    irq_route_regs #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .active_i(active), .core_stat_i(core_stat),
        .en_o(en_q), .pol_o(pol_q), .sense_o(sense_q),
        .route_o(route_q), .stat_clr_o(stat_clr)
    );

    irq_route_cond #(.NUM_SRC(NUM_SRC)) cond_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .en_i(en_q), .pol_i(pol_q), .sense_i(sense_q),
        .clr_i(stat_clr), .pend_o(pend)
    );

    irq_route_fabric #(.NUM_SRC(NUM_SRC), .NUM_PAR(NUM_PAR), .NUM_CORE(NUM_CORE)) fabric_i (
        .pend_i(pend), .en_i(en_q), .route_i(route_q),
        .active_o(active), .core_stat_o(core_stat), .line_o(irq_line_o)
    );
endmodule

// File: rtl/irq_route_chk.sv
// Assertion checker for irq_route_ctrl, attached by bind below.
// Watches the enable-register access rules, edge-latch clearing on disable,
// and the consistency of output lines with the status words.
module irq_route_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_LINE = 16,
    parameter int NUM_CORE = 4
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              bus_wr_i,
    input logic [ADDR_W-1:0]                 bus_addr_i,
    input logic [DATA_W-1:0]                 bus_wdata_i,
    input logic [NUM_LINE-1:0]               irq_line_o,
    input logic [NUM_SRC-1:0]                en_q,
    input logic [NUM_SRC-1:0]                sense_q,
    input logic [NUM_SRC-1:0]                pend,
    input logic [NUM_SRC-1:0]                active,
    input logic [NUM_CORE-1:0][NUM_SRC-1:0]  core_stat
);
    logic [NUM_SRC-1:0] wb;
    assign wb = bus_wdata_i[NUM_SRC-1:0];

    // R2: set write adds the written ones and keeps every other bit.
    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == OFS_EN_SET) |=>
            ((en_q & $past(wb)) == $past(wb)) &&
            ((en_q & ~$past(wb)) == ($past(en_q) & ~$past(wb))));

    // R3: clear write removes every written one.
    p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == OFS_EN_CLR) |=> ((en_q & $past(wb)) == '0));

    // R3: no other cycle changes the enable mask.
    p_en_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && (bus_addr_i == OFS_EN_SET || bus_addr_i == OFS_EN_CLR))
            |=> $stable(en_q));

    // R7: an edge latch never survives a cycle with its source disabled.
    p_lat_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~en_q)) |=> ((pend & sense_q & ~$past(en_q)) == '0));

    // R9: a raised line needs an active source.
    p_line_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_line_o != '0) |-> (active != '0));

    // R10: a raised line needs some core status bit.
    p_line_core_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_line_o != '0) |-> (core_stat != '0));
endmodule

bind irq_route_ctrl irq_route_chk #(
    .NUM_SRC(NUM_SRC), .NUM_LINE(NUM_CORE*NUM_PAR), .NUM_CORE(NUM_CORE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .irq_line_o(irq_line_o), .en_q(en_q),
    .sense_q(sense_q), .pend(pend), .active(active), .core_stat(core_stat)
);

// File: tb/irq_route_ctrl_tb_top.sv
`timescale 1ns/1ps
// Testbench for irq_route_ctrl: a table of routing vectors, then directed tests.
module irq_route_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] lines;
    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    irq_route_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_line_o(lines)
    );

    typedef struct packed {
        logic [4:0]  idx;
        logic [7:0]  route;
        logic        pol;
        logic        lvl;
        logic [15:0] exp_lines;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  8'h11, 1'b1, 1'b1, 16'h0001},
        '{5'd5,  8'h24, 1'b1, 1'b1, 16'h0200},
        '{5'd31, 8'h88, 1'b0, 1'b0, 16'h8000},
        '{5'd17, 8'h42, 1'b0, 1'b1, 16'h0000},
        '{5'd10, 8'h31, 1'b1, 1'b1, 16'h0003},
        '{5'd3,  8'h16, 1'b1, 1'b1, 16'h0110},
        '{5'd20, 8'h00, 1'b1, 1'b1, 16'h0000},
        '{5'd9,  8'h80, 1'b1, 1'b1, 16'h0000}
    };

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        waitc(3);
        rst_n = 1'b1;
        waitc(1);

        // R1 reset state
        brd(8'h24, rv); chk(rv, 32'h0, "R1 enable after reset");
        brd(8'h30, rv); chk(rv, 32'hFFFF_FFFF, "R1 polarity after reset");
        brd(8'h34, rv); chk(rv, 32'h0, "R1 sense after reset");
        brd(8'h00, rv); chk(rv, 32'h0, "R1 route 0 after reset");
        brd(8'h1F, rv); chk(rv, 32'h0, "R1 route 31 after reset");
        chk({16'h0, lines}, 32'h0, "R1 lines after reset");

        // Table walk: R5 level sense, R9 routing, R10 core status, R8 status
        for (int k = 0; k < NV; k++) begin
            logic act;
            logic [31:0] bit_n;
            bit_n = 32'h1 << VECS[k].idx;
            act = (VECS[k].lvl == VECS[k].pol);
            src = '0;
            bwr(8'h2C, 32'hFFFF_FFFF);
            bwr(8'h34, 32'h0);
            bwr({3'b0, VECS[k].idx}, {24'h0, VECS[k].route});
            bwr(8'h30, VECS[k].pol ? 32'hFFFF_FFFF : ~bit_n);
            src = VECS[k].lvl ? bit_n : 32'h0;
            bwr(8'h28, bit_n);
            waitc(4);
            chk({16'h0, lines}, {16'h0, VECS[k].exp_lines}, $sformatf("R9 lines vector %0d", k));
            brd(8'h40, rv); chk(rv, act ? bit_n : 32'h0, $sformatf("R8 R5 status vector %0d", k));
            for (int c = 0; c < 4; c++) begin
                brd(8'h50 + 8'(4 * c), rv);
                chk(rv, (act && VECS[k].route[c]) ? bit_n : 32'h0,
                    $sformatf("R10 core %0d vector %0d", c, k));
            end
            bwr({3'b0, VECS[k].idx}, 32'h0);
        end
        src = '0;
        bwr(8'h2C, 32'hFFFF_FFFF);
        bwr(8'h30, 32'hFFFF_FFFF);

        // R2 set enables
        bwr(8'h28, 32'h0000_00F0);
        brd(8'h24, rv); chk(rv, 32'h0000_00F0, "R2 set F0");
        bwr(8'h28, 32'h0000_0003);
        brd(8'h24, rv); chk(rv, 32'h0000_00F3, "R2 zeros keep bits");
        // R3 clear enables
        bwr(8'h2C, 32'h0000_0030);
        brd(8'h24, rv); chk(rv, 32'h0000_00C3, "R3 clear 30");
        bwr(8'h2C, 32'hFFFF_FFFF);
        brd(8'h24, rv); chk(rv, 32'h0, "R3 clear all");

        // R4 route byte access
        bwr(8'h05, 32'h1234_5624);
        brd(8'h05, rv); chk(rv, 32'h0000_0024, "R4 route 5 readback");
        brd(8'h06, rv); chk(rv, 32'h0, "R4 neighbour route untouched");
        bwr(8'h05, 32'h0);

        // R8 polarity / sense readback
        bwr(8'h34, 32'hA5A5_0001);
        brd(8'h34, rv); chk(rv, 32'hA5A5_0001, "R8 sense readback");
        bwr(8'h34, 32'h0);

        // R11 unmapped reads
        brd(8'h28, rv); chk(rv, 32'h0, "R11 read 0x28");
        brd(8'h2C, rv); chk(rv, 32'h0, "R11 read 0x2C");
        brd(8'h20, rv); chk(rv, 32'h0, "R11 read 0x20");
        brd(8'h44, rv); chk(rv, 32'h0, "R11 read 0x44");
        brd(8'h60, rv); chk(rv, 32'h0, "R11 read 0x60");

        // R6 rising edge latch
        bwr(8'h07, 32'h11);
        bwr(8'h34, 32'h80);
        bwr(8'h28, 32'h80);
        src = 32'h80; waitc(3);
        src = 32'h0;  waitc(5);
        brd(8'h40, rv); chk(rv, 32'h80, "R6 rising latched");
        chk({16'h0, lines}, 32'h1, "R6 line from edge latch");

        // R7 status write-one clear
        bwr(8'h40, 32'h7F);
        brd(8'h40, rv); chk(rv, 32'h80, "R7 zero bits keep latch");
        bwr(8'h40, 32'h80);
        brd(8'h40, rv); chk(rv, 32'h0, "R7 write-one clears");
        chk({16'h0, lines}, 32'h0, "R7 line drops");

        // R6 falling edge with polarity 0
        bwr(8'h30, ~32'h80);
        src = 32'h80; waitc(4);
        brd(8'h40, rv); chk(rv, 32'h0, "R6 rising ignored when falling selected");
        src = 32'h0;  waitc(4);
        brd(8'h40, rv); chk(rv, 32'h80, "R6 falling latched");

        // R7 disable clears latch
        bwr(8'h2C, 32'h80);
        bwr(8'h28, 32'h80);
        brd(8'h40, rv); chk(rv, 32'h0, "R7 disable cleared latch");
        bwr(8'h2C, 32'hFFFF_FFFF);
        bwr(8'h34, 32'h0);
        bwr(8'h30, 32'hFFFF_FFFF);
        bwr(8'h07, 32'h0);

        // R12 disabled source is silent
        bwr(8'h02, 32'h11);
        src = 32'h4; waitc(4);
        chk({16'h0, lines}, 32'h0, "R12 disabled line low");
        brd(8'h40, rv); chk(rv, 32'h0, "R12 disabled status");
        brd(8'h50, rv); chk(rv, 32'h0, "R12 disabled core status");
        bwr(8'h28, 32'h4);
        chk({16'h0, lines}, 32'h1, "R12 line after enable");

        // R5 two-edge latency on level release
        src = 32'h0;
        waitc(1);
        chk({16'h0, lines}, 32'h1, "R5 line after one edge");
        waitc(1);
        chk({16'h0, lines}, 32'h0, "R5 line after two edges");

        // R9 OR of two sources on one line
        bwr(8'h09, 32'h11);
        src = 32'h204;
        bwr(8'h28, 32'h204);
        waitc(3);
        chk({16'h0, lines}, 32'h1, "R9 two sources");
        bwr(8'h2C, 32'h4);
        chk({16'h0, lines}, 32'h1, "R9 one remaining source");
        bwr(8'h2C, 32'h200);
        chk({16'h0, lines}, 32'h0, "R9 none remaining");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule